// File: doc/BRIEF.md
# Dual-Rail Pipeline Register Stage

This block is one register stage of a delay-insensitive pipeline. Every data bit travels on two wires, a true rail and a false rail. The stage stores each rail in a two-input threshold gate with hysteresis. One input of that gate is the incoming rail and the other is the inverted acknowledge from the downstream stage. As a result, the stage takes in a DATA wavefront only while the downstream stage asks for DATA. It takes in a NULL wavefront only while the downstream stage asks for NULL.

A completion tree sits behind the storage gates. It ORs the two rails of each bit and then merges the per-bit results through four-input all-asserted threshold gates. It raises the acknowledge to the upstream stage once every stored bit carries DATA, and drops it once every stored bit is NULL. A parameterised threshold-gate module supplies every gate in the stage. It covers any plain m-of-n threshold and one weighted four-input variant.

Each hysteresis gate is modelled with a state register, updated on `clk`, that feeds back into a combinational set/hold term. This makes the stage synthesizable and free of combinational loops. The outputs follow the inputs within the same cycle, and the state register holds them from the next rising edge onward.

Top module: `ncl_pipe_stage`

## Requirements
- R1: Each bit uses two rails: true=1 with false=0 is logic one, true=0 with false=1 is logic zero, and both low is NULL. While `ack_in` is low, a DATA word at the inputs appears unchanged on `out_t`/`out_f` within one clock cycle.
- R2: If the inputs never carry a bit with both rails high and follow the handshake, no output bit ever has both rails high.
- R3: A plain threshold gate with threshold m and n inputs drives its output high whenever at least m of its inputs are high.
- R4: Once a threshold gate's output is high, it stays high until all of its inputs are low. While its output is low, it stays low until its set condition is met.
- R5: The weighted four-input gate, with inputs A=bit 0, B=bit 1, C=bit 2 and D=bit 3, sets when A&B, A&C, A&D or B&C&D is true. It otherwise follows R4.
- R6: While `ack_in` stays low, the stored DATA is held on the outputs even after the inputs return to NULL.
- R7: While `ack_in` stays high, no output rail rises: new DATA at the inputs is not accepted. Stored DATA is held until the inputs are NULL.
- R8: `ack_out` rises only when every output bit holds DATA. It stays low while only some bits hold DATA.
- R9: `ack_out` falls only when every output bit is NULL. It stays high while only some bits have returned to NULL.
- R10: `ack_out` changes exactly twice per wavefront pair: one rise for the DATA wavefront and one fall for the NULL wavefront.
- R11: While `rst_n` is low, all output rails and `ack_out` are low, whatever the inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the hysteresis state registers |
| rst_n | input | 1 | Synchronous active-low reset; forces NULL and request-for-DATA |
| in_t | input | WIDTH | True rails of the incoming bundle |
| in_f | input | WIDTH | False rails of the incoming bundle |
| ack_in | input | 1 | Acknowledge from the next stage (1 = request NULL, 0 = request DATA) |
| out_t | output | WIDTH | True rails of the stored bundle |
| out_f | output | WIDTH | False rails of the stored bundle |
| ack_out | output | 1 | Acknowledge to the previous stage (1 = all DATA, 0 = all NULL) |

## Verification
A storage gate that loses its hysteresis state shows up in the first cycle after the inputs go NULL while `ack_in` is still low: that bit's rail drops early and the acknowledge falls too soon. A completion node stuck in the wrong state shows up as `ack_out` rising during a partly arrived DATA word, or falling during a partly returned NULL word. Such a fault is also visible as a wrong toggle count by the end of that wavefront pair. The two standalone gate instances are swept over every input pattern from both prior output states, so a wrong set term or a missing hold shows up in the cycle the pattern is applied.

// File: rtl/ncl_pipe_pkg.sv
// Shared sizing helpers for the dual-rail stage.
// Assumes a four-input merge at every level of the completion tree.
package ncl_pipe_pkg;

    // Number of nodes at a given level of a four-way merge tree.
    function automatic int tree_width(input int n, input int lvl);
        int w;
        w = n;
        for (int k = 0; k < lvl; k++) begin
            w = (w + 3) / 4;
        end
        return w;
    endfunction

    // Number of merge levels needed to reduce n nodes to one.
    function automatic int tree_levels(input int n);
        int w;
        int l;
        w = n;
        l = 0;
        while (w > 1) begin
            w = (w + 3) / 4;
            l++;
        end
        return l;
    endfunction

    // Bit offset of a level inside the flattened node vector.
    function automatic int tree_offset(input int n, input int lvl);
        int s;
        s = 0;
        for (int k = 0; k < lvl; k++) begin
            s = s + tree_width(n, k);
        end
        return s;
    endfunction

endpackage

// File: rtl/ncl_thresh_gate.sv
// Threshold gate with hysteresis (m-of-n, or weighted 3-of-4 variant).
// The output sets when the set term is true and holds high until every
// input is low. The hold state is a register updated on clk, which
// avoids a combinational feedback loop. Assumes WEIGHTED is used only
// with N_IN == 4, where in_bits[0] carries the double-weight input.
module ncl_thresh_gate #(
    parameter int N_IN     = 4,
    parameter int THRESH   = 4,
    parameter bit WEIGHTED = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] in_bits,
    output logic            gate_out
);

    logic set_c;
    logic hold_q;

    generate
        if (WEIGHTED) begin : g_w34
            // Weighted set: A counts twice, so A with any other input or B&C&D sets.
            assign set_c = (in_bits[0] & in_bits[1]) |
                           (in_bits[0] & in_bits[2]) |
                           (in_bits[0] & in_bits[3]) |
                           (in_bits[1] & in_bits[2] & in_bits[3]);
        end else begin : g_plain
            // Plain set: at least THRESH inputs asserted.
            assign set_c = ($countones(in_bits) >= THRESH);
        end
    endgenerate

    // Output: set, or hold the prior high while any input is still high.
    assign gate_out = rst_n & (set_c | (hold_q & (|in_bits)));

    // State: remember the present output for the hold term.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= gate_out;
    end

endmodule

// File: rtl/ncl_dr_bit_cell.sv
// One dual-rail bit of the stage: a two-input hysteresis gate per rail,
// with inputs {inverted ack, rail}, and a 1-of-2 gate that flags the
// bit as complete when either stored rail is high.
// Assumes the upstream stage never drives both rails high.
module ncl_dr_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_t,
    input  logic rail_f,
    input  logic ack_n,
    output logic q_t,
    output logic q_f,
    output logic done
);

    logic [1:0] rail_in;
    logic [1:0] rail_q;

    assign rail_in = {rail_f, rail_t};

    generate
        for (genvar r = 0; r < 2; r++) begin : g_rail
            ncl_thresh_gate #(
                .N_IN    (2),
                .THRESH  (2),
                .WEIGHTED(1'b0)
            ) u_th22 (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_bits ({ack_n, rail_in[r]}),
                .gate_out(rail_q[r])
            );
        end
    endgenerate

    ncl_thresh_gate #(
        .N_IN    (2),
        .THRESH  (1),
        .WEIGHTED(1'b0)
    ) u_th12 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_bits (rail_q),
        .gate_out(done)
    );

    assign q_t = rail_q[0];
    assign q_f = rail_q[1];

endmodule

// File: rtl/ncl_completion_tree.sv
// Merges per-bit completion flags through four-input all-asserted
// hysteresis gates. The output rises when every flag is high and falls
// when every flag is low. A short group repeats its first member.
module ncl_completion_tree
    import ncl_pipe_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] done_bits,
    output logic             all_done
);

    localparam int LEVELS = tree_levels(WIDTH);
    localparam int TOTAL  = tree_offset(WIDTH, LEVELS + 1);

    logic [TOTAL-1:0] nodes;

    assign nodes[WIDTH-1:0] = done_bits;

    generate
        for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
            localparam int W_IN    = tree_width(WIDTH, lvl);
            localparam int W_OUT   = tree_width(WIDTH, lvl + 1);
            localparam int OFS_IN  = tree_offset(WIDTH, lvl);
            localparam int OFS_OUT = tree_offset(WIDTH, lvl + 1);
            for (genvar g = 0; g < W_OUT; g++) begin : g_grp
                logic [3:0] grp;
                for (genvar k = 0; k < 4; k++) begin : g_in
                    if (g * 4 + k < W_IN) begin : g_real
                        assign grp[k] = nodes[OFS_IN + g * 4 + k];
                    end else begin : g_pad
                        assign grp[k] = nodes[OFS_IN + g * 4];
                    end
                end
                ncl_thresh_gate #(
                    .N_IN    (4),
                    .THRESH  (4),
                    .WEIGHTED(1'b0)
                ) u_th44 (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .in_bits (grp),
                    .gate_out(nodes[OFS_OUT + g])
                );
            end
        end
    endgenerate

    assign all_done = nodes[TOTAL-1];

endmodule

// File: rtl/ncl_pipe_stage.sv
// Dual-rail pipeline register stage. Stores WIDTH dual-rail bits in
// hysteresis gates gated by the inverted downstream acknowledge, and
// reports completion of the stored word upstream through ack_out.
// Assumes both neighbours follow the four-phase DATA/NULL handshake.
module ncl_pipe_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_t,
    input  logic [WIDTH-1:0] in_f,
    input  logic             ack_in,
    output logic [WIDTH-1:0] out_t,
    output logic [WIDTH-1:0] out_f,
    output logic             ack_out
);

    logic             ack_n;
    logic [WIDTH-1:0] done_bits;

    // Request polarity seen by the storage gates.
    assign ack_n = ~ack_in;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            ncl_dr_bit_cell u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .rail_t(in_t[b]),
                .rail_f(in_f[b]),
                .ack_n (ack_n),
                .q_t   (out_t[b]),
                .q_f   (out_f[b]),
                .done  (done_bits[b])
            );
        end
    endgenerate

    ncl_completion_tree #(
        .WIDTH(WIDTH)
    ) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_bits(done_bits),
        .all_done (ack_out)
    );

endmodule

// File: rtl/ncl_pipe_stage_chk.sv
// Protocol checker for ncl_pipe_stage, attached with bind.
// Assumes the environment follows the DATA/NULL handshake.
module ncl_pipe_stage_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] in_t,
    input logic [WIDTH-1:0] in_f,
    input logic             ack_in,
    input logic [WIDTH-1:0] out_t,
    input logic [WIDTH-1:0] out_f,
    input logic             ack_out
);

    // R2: legal inputs never produce an illegal output pair.
    p_no_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_t & in_f) == '0) |-> ((out_t & out_f) == '0));

    // R6: with ack_in low, no stored rail is dropped.
    p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_in && $past(!ack_in)) |->
        (((out_t & $past(out_t)) == $past(out_t)) &&
         ((out_f & $past(out_f)) == $past(out_f))));

    // R7: with ack_in high, no rail rises.
    p_block_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && $past(ack_in)) |->
        (((out_t & ~$past(out_t)) == '0) && ((out_f & ~$past(out_f)) == '0)));

    // R8: acknowledge rises only on a complete DATA word.
    p_ack_rise_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_out) |-> (&(out_t | out_f)));

    // R9: acknowledge falls only on a complete NULL word.
    p_ack_fall_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_out) |-> ((out_t | out_f) == '0));

    // R11: reset holds everything at NULL.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_null_r11: assert ((out_t == '0) && (out_f == '0) && !ack_out);
        end
    end

endmodule

bind ncl_pipe_stage ncl_pipe_stage_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ncl_pipe_stage_tb.sv
// Bench: sweeps every 8-bit word through full handshakes and checks the
// standalone threshold gates over all input patterns.
module ncl_pipe_stage_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_t = '0;
    logic [W-1:0] in_f = '0;
    logic         ack_in = 1'b0;
    logic [W-1:0] out_t;
    logic [W-1:0] out_f;
    logic         ack_out;
    logic [3:0]   g24_in = '0;
    logic [3:0]   w34_in = '0;
    logic         g24_out;
    logic         w34_out;

    int checks = 0;
    int errors = 0;
    int ack_toggles = 0;
    logic ack_seen = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ncl_pipe_stage #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .ack_in(ack_in),
        .out_t(out_t), .out_f(out_f), .ack_out(ack_out)
    );

    ncl_thresh_gate #(.N_IN(4), .THRESH(2), .WEIGHTED(1'b0)) u_th24 (
        .clk(clk), .rst_n(rst_n), .in_bits(g24_in), .gate_out(g24_out)
    );

    ncl_thresh_gate #(.N_IN(4), .THRESH(3), .WEIGHTED(1'b1)) u_w34 (
        .clk(clk), .rst_n(rst_n), .in_bits(w34_in), .gate_out(w34_out)
    );

    // Count acknowledge edges, sampled away from both clock edges.
    always @(posedge clk) begin
        #2;
        if (ack_out !== ack_seen) begin
            ack_toggles++;
            ack_seen = ack_out;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] t, input logic [W-1:0] f, input logic a);
        @(negedge clk);
        in_t = t;
        in_f = f;
        ack_in = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check_pipe(input logic [W-1:0] et, input logic [W-1:0] ef,
                              input logic ea, input string req);
        check(out_t === et, req, 32'(out_t), 32'(et));
        check(out_f === ef, req, 32'(out_f), 32'(ef));
        check(ack_out === ea, req, 32'(ack_out), 32'(ea));
        check((out_t & out_f) == '0, "R2", 32'(out_t & out_f), 32'd0);
    endtask

    function automatic logic w34_set(input logic [3:0] p);
        return (p[0] & p[1]) | (p[0] & p[2]) | (p[0] & p[3]) | (p[1] & p[2] & p[3]);
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: DATA at the inputs during reset must not reach the outputs.
        in_t = 8'hA5;
        in_f = 8'h5A;
        repeat (3) @(posedge clk);
        #1;
        check_pipe('0, '0, 1'b0, "R11");
        @(negedge clk);
        rst_n = 1'b1;
        in_t = '0;
        in_f = '0;
        @(posedge clk);
        #1;

        // R3 R4 R5: every pattern from a low and a high prior output.
        for (int pre = 0; pre < 2; pre++) begin
            for (int p = 0; p < 16; p++) begin
                logic e24;
                logic ew;
                @(negedge clk);
                g24_in = (pre != 0) ? 4'hF : 4'h0;
                w34_in = (pre != 0) ? 4'hF : 4'h0;
                @(posedge clk);
                #1;
                @(negedge clk);
                g24_in = 4'(p);
                w34_in = 4'(p);
                @(posedge clk);
                #1;
                e24 = ($countones(4'(p)) >= 2) | ((pre != 0) && (p != 0));
                ew  = w34_set(4'(p)) | ((pre != 0) && (p != 0));
                check(g24_out === e24, (pre != 0) ? "R4" : "R3", 32'(g24_out), 32'(e24));
                check(w34_out === ew, "R5", 32'(w34_out), 32'(ew));
                @(negedge clk);
                g24_in = 4'h0;
                w34_in = 4'h0;
                @(posedge clk);
                #1;
                check(!g24_out && !w34_out, "R4", 32'({g24_out, w34_out}), 32'd0);
            end
        end

        // R1 R6 R7 R8 R9 R10: full handshake for every word.
        for (int vi = 0; vi < 256; vi++) begin
            logic [W-1:0] v;
            int start;
            v = W'(vi);
            start = ack_toggles;
            drive(v & 8'h0F, ~v & 8'h0F, 1'b0);
            check_pipe(v & 8'h0F, ~v & 8'h0F, 1'b0, "R8");
            drive(v, ~v, 1'b0);
            check_pipe(v, ~v, 1'b1, "R1");
            if (v[0]) begin
                drive('0, '0, 1'b0);
                check_pipe(v, ~v, 1'b1, "R6");
                drive('0, '0, 1'b1);
                check_pipe('0, '0, 1'b0, "R9");
            end else begin
                drive(v, ~v, 1'b1);
                check_pipe(v, ~v, 1'b1, "R7");
                drive(v & 8'hF0, ~v & 8'hF0, 1'b1);
                check_pipe(v & 8'hF0, ~v & 8'hF0, 1'b1, "R9");
                drive('0, '0, 1'b1);
                check_pipe('0, '0, 1'b0, "R9");
            end
            drive(~v, v, 1'b1);
            check_pipe('0, '0, 1'b0, "R7");
            drive('0, '0, 1'b1);
            drive('0, '0, 1'b0);
            check_pipe('0, '0, 1'b0, "R7");
            check((ack_toggles - start) == 2, "R10", 32'(ack_toggles - start), 32'd2);
        end

        // R11: reset in the middle of a stored DATA word clears it.
        drive(8'h3C, 8'hC3, 1'b0);
        check_pipe(8'h3C, 8'hC3, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_pipe('0, '0, 1'b0, "R11");
        @(negedge clk);
        rst_n = 1'b1;
        in_t = '0;
        in_f = '0;
        @(posedge clk);
        #1;

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule